// File: doc/BRIEF.md
# Free-Running Compare/Capture Timer

This block is a 16-bit up-counter with two channel registers. Software selects the run mode through a small register port. In free-running mode the counter advances by one on every clock where the count enable is high. After the all-ones value it rolls over to zero and keeps counting. The same rollover tick raises a sticky overflow flag, which stays set until software clears it.

Each channel register works on its own as either a compare register or a capture register. Both can compare, both can capture, or one can do each. A compare channel produces a one-clock interrupt pulse when the count reaches its value. Compare matches can also toggle a single timer output pin. A separate output enable forces that pin to a programmable default level. A capture channel synchronizes its trigger input and latches the counter on each rising edge, then pulses its interrupt.

Top module: `frt_cc_timer`

## Requirements
- R1: The mode field is control bits [1:0]. The value 01 runs the counter. Any other value holds the counter at 0000h, and no compare match is produced.
- R2: In run mode the counter increments by one on each clock edge where `cnt_en_i` is high and holds its value otherwise. Reading address 4 returns the counter.
- R3: On the tick where the counter holds FFFFh, the next value is 0000h and the overflow flag is set at that same edge. Counting then continues.
- R4: The overflow flag (status address 1, bit 0) stays set until a write of 1 to status bit 0 clears it. A write of 0 has no effect. If a clear and a hardware set fall on the same edge, the set wins.
- R5: A channel in compare mode produces an interrupt pulse one clock long on `irq_o[k]`. The pulse starts at the edge of a tick on which the counter equals that channel's value. Channel 0 is at address 2 and channel 1 at address 3.
- R6: Matches are evaluated only on ticks. A channel value written equal to a counter that is held by a low enable gives exactly one match, at the next tick.
- R7: Control bit 2 (channel 0) or bit 3 (channel 1) set to 1 selects capture mode. A rising edge on `cap_i[k]` passes through a two-flop synchronizer. At the third clock edge after the input rises, the channel loads the counter value present before that edge, and its interrupt pulses for one clock. A capture that falls on the same edge as a software write wins.
- R8: The two channels choose compare or capture independently. A channel in capture mode never produces a compare match.
- R9: While output enable (control bit 4) is 1, each compare match of a channel whose toggle enable is set inverts `pin_o` at the match edge. Toggle enable is control bit 6 for channel 0 and bit 7 for channel 1. Matches on both channels at the same edge cancel.
- R10: While output enable is 0, `pin_o` is driven to the default level (control bit 5) from the next edge onward.
- R11: After reset the counter, channel values, control, overflow flag, interrupts and pin are all 0.
- R12: Reading address 0 returns the control byte. Unused addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count-clock enable |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| cap_i | input | 2 | Capture triggers, one per channel |
| irq_o | output | 2 | Per-channel interrupt pulses |
| pin_o | output | 1 | Timer output pin |

## Verification
A behavioural reference model tracks the counter, flag, channel values, synchronizers and pin, and is compared with the outputs every clock while the read address rotates. The stimulus has four distinct parts:
- A steady count enable and a gapped count enable; these separate counting from holding.
- A held counter with a channel rewritten to the current value; this exposes level-triggered or doubled matches.
- Both channels set to compare, then mixed, then both set to capture, with short and long trigger pulses; these expose swapped modes or a wrong synchronizer depth.
- A full rollover with a clear written on the same edge as the set, plus mode values 00, 10 and 11; these pin down the set priority and the stop behaviour.

// File: rtl/frt_pkg.sv
package frt_pkg;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 3;
  localparam int NCH    = 2;

  localparam logic [1:0] MODE_FREE = 2'b01;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_CH0  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd4;

  typedef struct packed {
    logic [NCH-1:0] tgl_en;
    logic           dflt;
    logic           oe;
    logic [NCH-1:0] cap_mode;
    logic [1:0]     mode;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/frt_counter.sv
module frt_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         en_i,
  input  logic         clr_ovf_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q;
  logic         ovf_q;
  logic         wrap;

  assign wrap = run_i & en_i & (cnt_q == {W{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (!run_i)    cnt_q <= '0;
      else if (en_i) cnt_q <= cnt_q + 1'b1;
      // hardware set wins over software clear
      if (wrap)           ovf_q <= 1'b1;
      else if (clr_ovf_i) ovf_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  p_stop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_o == '0);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !en_i) |=> cnt_o == $past(cnt_o));
  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && en_i && cnt_o == {W{1'b1}}) |=> (cnt_o == '0 && ovf_o));
  p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !clr_ovf_i) |=> ovf_o);
endmodule

// File: rtl/frt_channel.sv
module frt_channel #(
  parameter int W      = 16,
  parameter int SYNC_N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] cnt_i,
  input  logic         cap_mode_i,
  input  logic         cap_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] val_o,
  output logic         match_o,
  output logic         irq_o
);
  logic [SYNC_N:0] sh_q;
  logic [W-1:0]    val_q;
  logic            irq_q;
  logic            rise, capt;

  assign rise    = sh_q[SYNC_N-1] & ~sh_q[SYNC_N];
  assign capt    = rise & cap_mode_i;
  assign match_o = tick_i & ~cap_mode_i & (cnt_i == val_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      val_q <= '0;
      irq_q <= 1'b0;
    end else begin
      sh_q  <= {sh_q[SYNC_N-1:0], cap_i};
      irq_q <= match_o | capt;
      if (capt)      val_q <= cnt_i;
      else if (wr_i) val_q <= wdata_i;
    end
  end

  assign val_o = val_q;
  assign irq_o = irq_q;

  p_irq_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  p_match_irq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> irq_o);
  p_capture_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capt |=> val_o == $past(cnt_i));
endmodule

// File: rtl/frt_out_ctrl.sv
module frt_out_ctrl #(
  parameter int NCH = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] match_i,
  input  logic [NCH-1:0] tgl_en_i,
  input  logic           oe_i,
  input  logic           dflt_i,
  output logic           pin_o
);
  logic pin_q;
  logic flip;

  assign flip = ^(match_i & tgl_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pin_q <= 1'b0;
    else if (oe_i) pin_q <= pin_q ^ flip;
    else           pin_q <= dflt_i;
  end

  assign pin_o = pin_q;

  p_default_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |=> pin_o == $past(dflt_i));
  p_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_i && (match_i & tgl_en_i) == '0) |=> $stable(pin_o));
endmodule

// File: rtl/frt_cc_timer.sv
module frt_cc_timer
  import frt_pkg::*;
#(
  parameter int CW     = CNT_W,
  parameter int SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CW-1:0]     wdata_i,
  output logic [CW-1:0]     rdata_o,
  input  logic [NCH-1:0]    cap_i,
  output logic [NCH-1:0]    irq_o,
  output logic              pin_o
);
  ctrl_t          ctrl_q;
  logic           run, tick, ovf, clr_ovf;
  logic [CW-1:0]  cnt;
  logic [CW-1:0]  val [NCH];
  logic [NCH-1:0] match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       ctrl_q <= '0;
    else if (we_i && addr_i == A_CTRL) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  assign run     = (ctrl_q.mode == MODE_FREE);
  assign tick    = run & cnt_en_i;
  assign clr_ovf = we_i & (addr_i == A_STAT) & wdata_i[0];

  frt_counter #(.W(CW)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .en_i      (cnt_en_i),
    .clr_ovf_i (clr_ovf),
    .cnt_o     (cnt),
    .ovf_o     (ovf)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic wr;
    assign wr = we_i & (addr_i == A_CH0 + ADDR_W'(k));
    frt_channel #(.W(CW), .SYNC_N(SYNC_N)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick),
      .cnt_i      (cnt),
      .cap_mode_i (ctrl_q.cap_mode[k]),
      .cap_i      (cap_i[k]),
      .wr_i       (wr),
      .wdata_i    (wdata_i),
      .val_o      (val[k]),
      .match_o    (match[k]),
      .irq_o      (irq_o[k])
    );
  end

  frt_out_ctrl #(.NCH(NCH)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .match_i  (match),
    .tgl_en_i (ctrl_q.tgl_en),
    .oe_i     (ctrl_q.oe),
    .dflt_i   (ctrl_q.dflt),
    .pin_o    (pin_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CTRL)      rdata_o = CW'(ctrl_q);
    else if (addr_i == A_STAT) rdata_o = CW'(ovf);
    else if (addr_i == A_CNT)  rdata_o = cnt;
    else
      for (int k = 0; k < NCH; k++)
        if (addr_i == A_CH0 + ADDR_W'(k)) rdata_o = val[k];
  end

  p_no_match_stopped_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> match == '0);
  p_capmode_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match & ctrl_q.cap_mode) == '0);
endmodule

// File: tb/tb_frt_cc_timer.sv
module tb_frt_cc_timer;
  localparam int PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  cap = '0, irq;
  logic        pin;

  int vecs = 0, errs = 0, cyc = 0;

  always #(PER/2) clk = ~clk;

  frt_cc_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(cnt_en), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .cap_i(cap), .irq_o(irq), .pin_o(pin)
  );

  // reference model
  logic [7:0]  m_ctrl;
  logic [15:0] m_cnt, m_v0, m_v1;
  logic        m_ovf, m_pin;
  logic [1:0]  m_irq;
  logic [2:0]  m_sh0, m_sh1;
  logic        t_tick, t_m0, t_m1, t_c0, t_c1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_cnt = 0; m_v0 = 0; m_v1 = 0; m_ovf = 0; m_pin = 0;
      m_irq = 0; m_sh0 = 0; m_sh1 = 0;
    end else begin
      t_tick = (m_ctrl[1:0] == 2'b01) && cnt_en;
      t_m0 = t_tick && !m_ctrl[2] && m_cnt == m_v0;
      t_m1 = t_tick && !m_ctrl[3] && m_cnt == m_v1;
      t_c0 = m_sh0[1] && !m_sh0[2] && m_ctrl[2];
      t_c1 = m_sh1[1] && !m_sh1[2] && m_ctrl[3];
      m_irq = {t_m1 | t_c1, t_m0 | t_c0};
      if (m_ctrl[4]) m_pin = m_pin ^ (t_m0 & m_ctrl[6]) ^ (t_m1 & m_ctrl[7]);
      else m_pin = m_ctrl[5];
      if (t_tick && m_cnt == 16'hFFFF) m_ovf = 1;
      else if (we && addr == 1 && wdata[0]) m_ovf = 0;
      if (t_c0) m_v0 = m_cnt; else if (we && addr == 2) m_v0 = wdata;
      if (t_c1) m_v1 = m_cnt; else if (we && addr == 3) m_v1 = wdata;
      m_sh0 = {m_sh0[1:0], cap[0]};
      m_sh1 = {m_sh1[1:0], cap[1]};
      if (m_ctrl[1:0] != 2'b01) m_cnt = 0;
      else if (cnt_en) m_cnt = m_cnt + 16'd1;
      if (we && addr == 0) m_ctrl = wdata[7:0];
    end
  end

  function automatic logic [15:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return {8'h00, m_ctrl};
      3'd1: return {15'd0, m_ovf};
      3'd2: return m_v0;
      3'd3: return m_v1;
      3'd4: return m_cnt;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string rd_tag(input logic [2:0] a);
    case (a)
      3'd0: return "R12 ctrl";
      3'd1: return "R4 ovf";
      3'd2, 3'd3: return "R7 chval";
      3'd4: return "R2 cnt";
      default: return "R12 unused";
    endcase
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  // compare every clock, away from the active edge; R11 covered by the first compares
  always @(negedge clk) begin
    cyc++;
    vecs += 3;
    if (irq !== m_irq) begin
      errs++; $display("FAIL R5/R7 irq cyc %0d: got %b exp %b", cyc, irq, m_irq);
    end
    if (pin !== m_pin) begin
      errs++; $display("FAIL R9/R10 pin cyc %0d: got %b exp %b", cyc, pin, m_pin);
    end
    if (rdata !== exp_rd(addr)) begin
      errs++; $display("FAIL %s addr %0d cyc %0d: got %h exp %h",
                       rd_tag(addr), addr, cyc, rdata, exp_rd(addr));
    end
    if (cyc > 190000) begin
      errs++; $display("FAIL watchdog: run did not finish");
      summary();
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic idle(input int n, input logic en);
    for (int i = 0; i < n; i++) begin
      step(); we = 0; cnt_en = en; addr = 3'(i % 6);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    step(); we = 1; addr = a; wdata = d;
    step(); we = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(12, 1);                          // R11, R1: mode 00 holds counter at 0
    wr(2, 16'd5); wr(3, 16'd9);
    wr(0, 16'h00D1);                      // R12, run, oe, both toggles
    idle(24, 1);                          // R5, R9
    for (int i = 0; i < 40; i++) begin    // R2 gapped enable
      step(); cnt_en = (i % 3 != 0); addr = 3'(i % 5);
    end
    wr(3, 16'd200);
    step(); cnt_en = 0;                   // R6: hold, rewrite to current value
    wr(2, m_cnt);
    idle(6, 0);
    idle(4, 1);
    wr(0, 16'h0055);                      // R8: ch0 capture, ch1 compare
    idle(3, 1);
    step(); cap = 2'b01; idle(4, 1);
    step(); cap = 2'b00; idle(5, 1);
    step(); cap = 2'b01; step(); cap = 2'b00; idle(6, 1);  // R7 one-clock pulse
    wr(0, 16'h001D);                      // R8 both capture
    step(); cap = 2'b11; idle(3, 1);
    step(); cap = 2'b10; idle(4, 1);
    step(); cap = 2'b00; idle(6, 1);
    wr(0, 16'h0061);                      // R10 oe off, default 1
    idle(8, 1);
    wr(0, 16'h0051);                      // oe on, ch0 toggle
    wr(2, m_cnt + 16'd4);
    idle(8, 1);
    wr(0, 16'h0002); idle(6, 1);          // R1 mode 10
    wr(0, 16'h0003); idle(6, 1);          // R1 mode 11
    wr(1, 16'h0001); idle(3, 1);          // R4 clear when already clear
    wr(2, 16'hFFFF); wr(3, 16'h0000);
    wr(0, 16'h00D1);
    cnt_en = 1;
    while (m_cnt != 16'hFFFF) begin step(); we = 0; addr = 3'(cyc % 6); end
    we = 1; addr = 1; wdata = 16'h0001;   // R4 clear on the set edge: set wins; R3 wrap
    step(); we = 0;
    idle(8, 1);
    wr(1, 16'h0000); idle(4, 1);          // R4 write 0 has no effect
    wr(1, 16'h0001); idle(6, 1);          // R4 clear
    summary();
  end
endmodule